// File: doc/BRIEF.md
# Pin Edge Interrupt and Wakeup Detector

This block watches a bank of asynchronous pin inputs and reports edges on them. Each pin first passes through a flop synchronizer. The block then compares the current synchronized sample with the one from the cycle before, which yields one rising-edge pulse and one falling-edge pulse per pin. Two interrupt masks select which of these pulses count as interrupt events. A qualified event sets a sticky status bit for its pin. The interrupt line is high while any status bit is set. Software clears status bits by writing ones through a clear command.

A second, independent pair of masks selects which edges drive the wakeup line. This path has no sticky state. The wakeup line pulses in the cycle in which an enabled edge is seen, and it works even when every interrupt mask is zero. Only edges are detected: a pin that stays at a steady level, high or low, never produces an event.

Configuration uses a single-cycle write strobe with a 3-bit target select and a data word. There is no handshake on this port, and a write always completes in the cycle it is presented.

Top module: `edgewake_detector`

## Requirements
- R1: When a pin's bit is set in the rising interrupt mask (select code 0) and that pin goes from 0 to 1, its status bit reads 1 at the third rising clock edge after the pin change.
- R2: When a pin's bit is set in the falling interrupt mask (select code 1) and that pin goes from 1 to 0, its status bit is set with the same latency as in R1.
- R3: A pin with its bit set in both interrupt masks sets its status bit on either edge; a pin with neither bit set never sets its status bit.
- R4: A pin held at a constant level produces no event, so a status bit that has been cleared stays clear while its pin does not change.
- R5: A write with select code 4 clears every status bit whose data bit is 1 and leaves every status bit whose data bit is 0 unchanged; the result is visible after the write cycle's clock edge.
- R6: When a new qualified edge and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: `irq_o` is high exactly when at least one status bit is 1.
- R8: The wakeup line is high for the single cycle in which a synchronized edge is enabled by the rising wake mask (select code 2) or the falling wake mask (select code 3); this is the cycle between the second and third clock edges after the pin change. Wake masks never affect the status bits, and interrupt masks never affect the wakeup line.
- R9: Reset clears all four masks and all status bits, and drives `irq_o` and `wake_o` low.
- R10: Writes with select codes 5, 6 or 7 change no mask and clear no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Asynchronous pin levels |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_sel_i | input | 3 | Write target: 0 rising interrupt mask, 1 falling interrupt mask, 2 rising wake mask, 3 falling wake mask, 4 status clear |
| wr_data_i | input | NUM_PINS | Mask value, or clear bits for code 4 |
| status_o | output | NUM_PINS | Sticky per-pin event status |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Wakeup request pulse |

## Verification
The assertions assume that the write strobe is the only way the masks and status can change. They also assume that any rise of the interrupt line comes from an event qualified in the cycle before. Both assumptions hold only if the pins settle low while reset is held, because the synchronizer and edge history both reset to zero and a pin that is high at release would otherwise look like a rising edge. The stimulus therefore keeps every pin low through reset. It changes pins and write controls only on falling clock edges, and it spaces pin changes at least three cycles apart, so each edge reaches the status register on its own before the next one starts.

// File: rtl/edgewake_pkg.sv
package edgewake_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_RISE_IRQ  = 3'd0,
    SEL_FALL_IRQ  = 3'd1,
    SEL_RISE_WAKE = 3'd2,
    SEL_FALL_WAKE = 3'd3,
    SEL_CLEAR     = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/edgewake_sync.sv
module edgewake_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/edgewake_edge.sv
module edgewake_edge #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= level_i;
  end

  assign rise_o = level_i & ~last_q;
  assign fall_o = ~level_i & last_q;

  // R1/R2: a reported edge must show up as a changed level history one cycle later
  p_edge_hist_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_o | fall_o)) |=> ((last_q & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/edgewake_cfg.sv
module edgewake_cfg
  import edgewake_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rise_irq_o,
  output logic [WIDTH-1:0] fall_irq_o,
  output logic [WIDTH-1:0] rise_wake_o,
  output logic [WIDTH-1:0] fall_wake_o,
  output logic [WIDTH-1:0] clr_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_irq_o  <= '0;
      fall_irq_o  <= '0;
      rise_wake_o <= '0;
      fall_wake_o <= '0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_RISE_IRQ:  rise_irq_o  <= wr_data_i;
        SEL_FALL_IRQ:  fall_irq_o  <= wr_data_i;
        SEL_RISE_WAKE: rise_wake_o <= wr_data_i;
        SEL_FALL_WAKE: fall_wake_o <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_o = '0;
    if (wr_en_i && sel == SEL_CLEAR) clr_o = wr_data_i;
  end

  // R10: codes above the clear code leave every mask untouched
  p_bad_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i > 3'd4) |=>
      ($stable(rise_irq_o) && $stable(fall_irq_o) &&
       $stable(rise_wake_o) && $stable(fall_wake_o)));
endmodule

// File: rtl/edgewake_status.sv
module edgewake_status #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= (status_o & ~clr_i) | set_i;
  end

  // R6: an event always lands, even against a clear of the same bit
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

  // R5: cleared bits without a competing event read zero
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((status_o & $past(clr_i & ~set_i)) == '0));

  // R4: bits with neither event nor clear keep their value
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o ^ $past(status_o)) & ~$past(set_i | clr_i)) == '0);
endmodule

// File: rtl/edgewake_detector.sv
module edgewake_detector
  import edgewake_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                wr_en_i,
  input  logic [SEL_W-1:0]    wr_sel_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] pins_sync, rise, fall;
  logic [NUM_PINS-1:0] m_rise_irq, m_fall_irq, m_rise_wake, m_fall_wake, clr;
  logic [NUM_PINS-1:0] irq_hits, wake_hits;

  edgewake_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(pins_sync));

  edgewake_edge #(.WIDTH(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(pins_sync), .rise_o(rise), .fall_o(fall));

  edgewake_cfg #(.WIDTH(NUM_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rise_irq_o(m_rise_irq), .fall_irq_o(m_fall_irq),
    .rise_wake_o(m_rise_wake), .fall_wake_o(m_fall_wake), .clr_o(clr));

  assign irq_hits  = (rise & m_rise_irq)  | (fall & m_fall_irq);
  assign wake_hits = (rise & m_rise_wake) | (fall & m_fall_wake);

  edgewake_status #(.WIDTH(NUM_PINS)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(irq_hits), .clr_i(clr), .status_o(status_o));

  assign irq_o  = |status_o;
  assign wake_o = |wake_hits;

  // R7: the interrupt line can only come up after a qualified event
  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|irq_hits));

  // R8: a wakeup needs at least one wake mask bit
  p_wake_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (|(m_rise_wake | m_fall_wake)));
endmodule

// File: tb/edgewake_detector_test.sv
module edgewake_detector_test;
  localparam int W  = 32;
  localparam int NV = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pins = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] status;
  logic         irq, wake;

  int checks = 0;
  int fails  = 0;

  localparam logic [W-1:0] V_RI [NV] = '{32'hFFFF_FFFF, 32'h0, 32'h0F0F_0F0F, 32'h0, 32'h0, 32'hAAAA_AAAA};
  localparam logic [W-1:0] V_FI [NV] = '{32'h0, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0, 32'h0, 32'h5555_5555};
  localparam logic [W-1:0] V_RW [NV] = '{32'h0, 32'h0, 32'h0, 32'h0000_0100, 32'h0, 32'h0};
  localparam logic [W-1:0] V_FW [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h8000_0000, 32'h0};
  localparam logic [W-1:0] V_PN [NV] = '{32'h0000_FFFF, 32'h00FF_00FF, 32'hFF00_00FF,
                                          32'hFF00_01FF, 32'h7F00_01FF, 32'h80FE_0000};

  always #4 clk = ~clk;

  edgewake_detector uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .status_o(status), .irq_o(irq), .wake_o(wake));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] prev, rs, fl, exp_st;
    logic exp_wk;
    do_reset();
    // R9 reset state
    chk("R9 status", status, '0);
    chk("R9 irq", {31'b0, irq}, '0);
    chk("R9 wake", {31'b0, wake}, '0);

    // Vector table: R1 R2 R3 R8 R7
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, V_RI[v]); wr(3'd1, V_FI[v]); wr(3'd2, V_RW[v]); wr(3'd3, V_FW[v]);
      wr(3'd4, 32'hFFFF_FFFF);
      prev = pins;
      rs = V_PN[v] & ~prev;
      fl = prev & ~V_PN[v];
      exp_st = (rs & V_RI[v]) | (fl & V_FI[v]);
      exp_wk = |((rs & V_RW[v]) | (fl & V_FW[v]));
      @(negedge clk) pins = V_PN[v];
      repeat (2) @(negedge clk);
      chk($sformatf("R8 wake vec%0d", v), {31'b0, wake}, {31'b0, exp_wk});
      @(negedge clk);
      chk($sformatf("R1 R2 R3 status vec%0d", v), status, exp_st);
      chk($sformatf("R7 irq vec%0d", v), {31'b0, irq}, {31'b0, |exp_st});
      chk($sformatf("R8 wake pulse ends vec%0d", v), {31'b0, wake}, '0);
    end

    // R6 set beats same-cycle clear
    do_reset();
    wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk) pins = 32'h1;
    repeat (3) @(negedge clk);
    chk("R1 bit0 set", status, 32'h1);
    pins = 32'h3;
    repeat (2) @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6 set wins", status, 32'h2);

    // R4 steady level does not retrigger
    wr(3'd4, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    chk("R4 level ignored", status, '0);

    // R5 partial clear, R7 follows status
    @(negedge clk) pins = 32'hF3;
    repeat (3) @(negedge clk);
    chk("R1 bits F0", status, 32'hF0);
    wr(3'd4, 32'h30);
    chk("R5 partial clear", status, 32'hC0);
    chk("R7 irq still high", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'hC0);
    chk("R5 rest cleared", status, '0);
    chk("R7 irq low", {31'b0, irq}, '0);

    // R10 unused codes, and R9 masks cleared by reset
    do_reset();
    wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    @(negedge clk) pins = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    chk("R10 R9 no wake", {31'b0, wake}, '0);
    @(negedge clk);
    chk("R10 R9 no status", status, '0);
    wr(3'd0, 32'h1);
    @(negedge clk) pins = 32'h0;
    repeat (3) @(negedge clk);
    chk("R10 R3 no falling mask", status, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule